// File: doc/BRIEF.md
# Glitch-Free PLL Bypass Clock Switch

This block drives one output clock from either a PLL output or a bypass clock. The bypass clock is itself picked from two sources: the always-running primary oscillator or the PLL's reference input. Every change of source is made without glitches. During a handover the output is held low for a few cycles, and no high or low phase comes out shorter than a phase of the clocks involved.

The control inputs are sampled in the oscillator domain. The block enters bypass when the bypass enable is set or when a forced safe-mode input is active. While it is in bypass, a reset to the PLL-side logic is held asserted, so the PLL can run freely and settle. That reset is asserted at once and released in step with the PLL clock. A busy flag covers each handover. A sticky wakeup interrupt marks the end of each move into or out of bypass and stays set until a clear strobe.

Top module: `pll_bypass_switch`

## Requirements
- R1: With `safe_force` low, `bypass_en`=1 drives `clk_out` from the bypass clock and `bypass_en`=0 drives it from `pll_clk`.
- R2: In bypass, `src_sel`=0 selects `osc_clk` and `src_sel`=1 selects `ref_clk` as the bypass clock.
- R3: `clk_out` never shows a high or low phase shorter than the shortest half period of the three source clocks, including during handovers. At most one source gate of each switch stage is open at any time.
- R4: While the sampled bypass request is active, `pll_rst_n` is low from the next oscillator edge onward. After the request is removed, `pll_rst_n` rises only on a `pll_clk` rising edge.
- R5: `busy` is high in the oscillator cycle after any sampled change of the bypass request or of `src_sel`. It stays high until the newly requested source alone drives the output.
- R6: `wake_irq` sets when a change of the bypass request has fully completed. It does not set for a change of `src_sel` alone. Once set, it stays set until it is cleared.
- R7: A one-cycle `irq_clr` clears `wake_irq` unless a completion happens in the same cycle; a completion wins.
- R8: During reset, `pll_rst_n`=0 and `wake_irq`=0, both switch stages are closed, and `busy`=1. The bypass request resets to active.
- R9: `safe_force`=1 forces bypass regardless of `bypass_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Primary oscillator; also the control clock |
| ref_clk | input | 1 | PLL reference clock, alternate bypass source |
| pll_clk | input | 1 | PLL output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass_en | input | 1 | Bypass request bit |
| src_sel | input | 1 | Bypass source: 0 oscillator, 1 reference |
| safe_force | input | 1 | Forced safe mode, implies bypass |
| irq_clr | input | 1 | Clear strobe for the wakeup interrupt |
| clk_out | output | 1 | Switched output clock |
| pll_rst_n | output | 1 | Active-low reset to PLL-side logic |
| busy | output | 1 | Handover in progress |
| wake_irq | output | 1 | Sticky transition-complete interrupt |

## Verification
`busy` is due in the oscillator cycle after the edge that samples a request change. The bench drives inputs on falling oscillator edges and reads `busy` at the next falling edge. Handover length depends on the ratio of the clocks, so the bench polls `busy` until it falls, under a bound. It then waits several output edges before measuring the output period against the selected source. `wake_irq` is due one oscillator cycle after completion, and the bench reads it only after `busy` has dropped. A phase-width monitor runs throughout the test to catch short pulses.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  // A two-input switch is settled when only the requested side is open.
  function automatic logic sw_settled(input logic want_b,
                                      input logic open_a,
                                      input logic open_b);
    return want_b ? (open_b & ~open_a) : (open_a & ~open_b);
  endfunction
endpackage

// File: rtl/pbs_sync.sv
module pbs_sync #(
  parameter int unsigned STAGES  = 2,
  parameter int unsigned WIDTH   = 1,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stg[s] <= {WIDTH{RST_VAL}};
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pbs_gf_mux.sv
module pbs_gf_mux #(
  parameter int unsigned STAGES = pbs_pkg::SYNC_STAGES
) (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst_n,
  input  logic pick_b,
  output logic clk_o,
  output logic open_a,
  output logic open_b
);
  logic want_a_s, want_b_s;

  // A side may open only after the other side's gate has closed.
  pbs_sync #(.STAGES(STAGES), .WIDTH(1), .RST_VAL(1'b0)) u_sync_a (
    .clk(clk_a), .arst_n(rst_n), .d(~pick_b & ~open_b), .q(want_a_s));
  pbs_sync #(.STAGES(STAGES), .WIDTH(1), .RST_VAL(1'b0)) u_sync_b (
    .clk(clk_b), .arst_n(rst_n), .d(pick_b & ~open_a), .q(want_b_s));

  // Gates change on the falling edge, while their own clock is low.
  always_ff @(negedge clk_a or negedge rst_n) begin
    if (!rst_n) open_a <= 1'b0;
    else        open_a <= want_a_s;
  end

  always_ff @(negedge clk_b or negedge rst_n) begin
    if (!rst_n) open_b <= 1'b0;
    else        open_b <= want_b_s;
  end

  assign clk_o = (clk_a & open_a) | (clk_b & open_b);
endmodule

// File: rtl/pbs_pll_rst.sv
module pbs_pll_rst #(
  parameter int unsigned STAGES = pbs_pkg::SYNC_STAGES
) (
  input  logic pll_clk,
  input  logic rst_n,
  input  logic byp_req,
  output logic pll_rst_n
);
  logic hold_n;
  assign hold_n = rst_n & ~byp_req;

  pbs_sync #(.STAGES(STAGES), .WIDTH(1), .RST_VAL(1'b0)) u_rel (
    .clk(pll_clk), .arst_n(hold_n), .d(1'b1), .q(pll_rst_n));
endmodule

// File: rtl/pbs_ctrl.sv
module pbs_ctrl #(
  parameter int unsigned STAGES = pbs_pkg::SYNC_STAGES
) (
  input  logic       osc_clk,
  input  logic       rst_n,
  input  logic       bypass_en,
  input  logic       src_sel,
  input  logic       safe_force,
  input  logic       irq_clr,
  input  logic [3:0] gates_raw,   // {byp_side, pll_side, ref_side, osc_side}
  output logic       byp_req,
  output logic       src_req,
  output logic       busy,
  output logic       wake_irq,
  output logic       wake_set
);
  import pbs_pkg::*;

  logic [3:0] gates_s;
  logic       byp_eff, byp_chg, pend;
  logic       src_ok, byp_ok;

  pbs_sync #(.STAGES(STAGES), .WIDTH(4), .RST_VAL(1'b0)) u_gsync (
    .clk(osc_clk), .arst_n(rst_n), .d(gates_raw), .q(gates_s));

  assign byp_eff = bypass_en | safe_force;
  assign byp_chg = byp_eff != byp_req;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_req <= 1'b1;
      src_req <= 1'b0;
    end else begin
      byp_req <= byp_eff;
      src_req <= src_sel;
    end
  end

  assign src_ok   = sw_settled(src_req, gates_s[0], gates_s[1]);
  assign byp_ok   = sw_settled(byp_req, gates_s[2], gates_s[3]);
  assign busy     = ~(src_ok & byp_ok);
  assign wake_set = pend & byp_ok;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      wake_irq <= 1'b0;
    end else begin
      pend <= (pend & ~wake_set) | byp_chg;
      if (wake_set)     wake_irq <= 1'b1;
      else if (irq_clr) wake_irq <= 1'b0;
    end
  end
endmodule

// File: rtl/pll_bypass_switch.sv
module pll_bypass_switch #(
  parameter int unsigned STAGES = pbs_pkg::SYNC_STAGES
) (
  input  logic osc_clk,
  input  logic ref_clk,
  input  logic pll_clk,
  input  logic rst_n,
  input  logic bypass_en,
  input  logic src_sel,
  input  logic safe_force,
  input  logic irq_clr,
  output logic clk_out,
  output logic pll_rst_n,
  output logic busy,
  output logic wake_irq
);
  logic byp_clk;
  logic byp_req, src_req, wake_set;
  logic g_osc, g_ref, g_pll, g_byp;

  // Stage 1: bypass source (oscillator or reference).
  pbs_gf_mux #(.STAGES(STAGES)) u_src_mux (
    .clk_a(osc_clk), .clk_b(ref_clk), .rst_n(rst_n), .pick_b(src_req),
    .clk_o(byp_clk), .open_a(g_osc), .open_b(g_ref));

  // Stage 2: PLL output or bypass clock.
  pbs_gf_mux #(.STAGES(STAGES)) u_out_mux (
    .clk_a(pll_clk), .clk_b(byp_clk), .rst_n(rst_n), .pick_b(byp_req),
    .clk_o(clk_out), .open_a(g_pll), .open_b(g_byp));

  pbs_ctrl #(.STAGES(STAGES)) u_ctrl (
    .osc_clk(osc_clk), .rst_n(rst_n), .bypass_en(bypass_en),
    .src_sel(src_sel), .safe_force(safe_force), .irq_clr(irq_clr),
    .gates_raw({g_byp, g_pll, g_ref, g_osc}),
    .byp_req(byp_req), .src_req(src_req), .busy(busy),
    .wake_irq(wake_irq), .wake_set(wake_set));

  pbs_pll_rst #(.STAGES(STAGES)) u_pll_rst (
    .pll_clk(pll_clk), .rst_n(rst_n), .byp_req(byp_req),
    .pll_rst_n(pll_rst_n));
endmodule

// File: rtl/pbs_checker.sv
module pbs_checker (
  input logic osc_clk,
  input logic pll_clk,
  input logic rst_n,
  input logic bypass_en,
  input logic src_sel,
  input logic safe_force,
  input logic irq_clr,
  input logic byp_req,
  input logic busy,
  input logic wake_irq,
  input logic wake_set,
  input logic pll_rst_n,
  input logic g_osc,
  input logic g_ref,
  input logic g_pll,
  input logic g_byp
);
  a_r3_src_onehot: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $onehot0({g_osc, g_ref}));
  a_r3_out_onehot: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $onehot0({g_pll, g_byp}));
  a_r4_hold_in_bypass: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (bypass_en | safe_force) |=> !pll_rst_n);
  a_r4_sync_release: assert property (@(posedge pll_clk) disable iff (!rst_n)
    $rose(pll_rst_n) |-> !byp_req);
  a_r5_busy_on_req: assert property (@(posedge osc_clk) disable iff (!rst_n)
    ((bypass_en | safe_force) != $past(bypass_en | safe_force)) |=> busy);
  a_r5_busy_on_src: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (src_sel != $past(src_sel)) |=> busy);
  a_r6_irq_sticky: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (wake_irq && !irq_clr) |=> wake_irq);
  a_r6_irq_on_done: assert property (@(posedge osc_clk) disable iff (!rst_n)
    wake_set |=> wake_irq);
  a_r7_irq_clear: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (irq_clr && !wake_set) |=> !wake_irq);
endmodule

bind pll_bypass_switch pbs_checker chk_i (
  .osc_clk(osc_clk), .pll_clk(pll_clk), .rst_n(rst_n),
  .bypass_en(bypass_en), .src_sel(src_sel), .safe_force(safe_force),
  .irq_clr(irq_clr), .byp_req(byp_req), .busy(busy), .wake_irq(wake_irq),
  .wake_set(wake_set), .pll_rst_n(pll_rst_n),
  .g_osc(g_osc), .g_ref(g_ref), .g_pll(g_pll), .g_byp(g_byp));

// File: tb/pll_bypass_switch_tb_top.sv
`timescale 1ns/1ps
module pll_bypass_switch_tb_top;
  localparam real OSC_HALF = 2.5;   // 200 MHz
  localparam real REF_HALF = 4.0;
  localparam real PLL_HALF = 1.5;
  localparam real MIN_PHASE = 1.45;

  logic osc_clk = 1'b0, ref_clk = 1'b0, pll_clk = 1'b0;
  logic rst_n = 1'b0;
  logic bypass_en = 1'b1, src_sel = 1'b0, safe_force = 1'b0, irq_clr = 1'b0;
  logic clk_out, pll_rst_n, busy, wake_irq;

  int total = 0;
  int bad = 0;
  int glitches = 0;
  real last_edge = -1.0;
  real last_rise = -1.0;
  real period = 0.0;

  always #(OSC_HALF) osc_clk = ~osc_clk;
  always #(REF_HALF) ref_clk = ~ref_clk;
  always #(PLL_HALF) pll_clk = ~pll_clk;

  pll_bypass_switch dut_i (
    .osc_clk(osc_clk), .ref_clk(ref_clk), .pll_clk(pll_clk), .rst_n(rst_n),
    .bypass_en(bypass_en), .src_sel(src_sel), .safe_force(safe_force),
    .irq_clr(irq_clr), .clk_out(clk_out), .pll_rst_n(pll_rst_n),
    .busy(busy), .wake_irq(wake_irq));

  // Phase-width and period monitor on the output.
  always @(posedge clk_out or negedge clk_out) begin
    if (last_edge >= 0.0 && ($realtime - last_edge) < MIN_PHASE) glitches++;
    last_edge = $realtime;
    if (clk_out) begin
      if (last_rise >= 0.0) period = $realtime - last_rise;
      last_rise = $realtime;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_period(input string req, input real exp);
    total++;
    if (period < exp - 0.01 || period > exp + 0.01) begin
      bad++;
      $display("FAIL %s: actual period=%0.3f expected=%0.3f", req, period, exp);
    end
  endtask

  task automatic wait_settle(input string req);
    int n = 0;
    while (busy && n < 400) begin
      @(negedge osc_clk);
      n++;
    end
    check({req, " settle"}, int'(busy), 0);
    repeat (8) @(posedge clk_out);
    @(negedge osc_clk);
  endtask

  task automatic t_reset();
    #1;
    check("R8 pll_rst_n", int'(pll_rst_n), 0);
    check("R8 wake_irq", int'(wake_irq), 0);
    check("R8 busy", int'(busy), 1);
    check("R8 clk_out quiet", int'(clk_out), 0);
    repeat (10) @(negedge osc_clk);
    rst_n = 1'b1;
  endtask

  task automatic t_bypass_osc();
    wait_settle("R2 osc");
    check_period("R1 R2 osc bypass", 2.0 * OSC_HALF);
    check("R4 held in bypass", int'(pll_rst_n), 0);
    check("R6 no irq without transition", int'(wake_irq), 0);
  endtask

  task automatic t_src_ref();
    src_sel = 1'b1;
    @(negedge osc_clk);
    check("R5 busy on src change", int'(busy), 1);
    wait_settle("R2 ref");
    check_period("R2 ref bypass", 2.0 * REF_HALF);
    check("R6 src change no irq", int'(wake_irq), 0);
  endtask

  task automatic t_exit();
    bypass_en = 1'b0;
    @(negedge osc_clk);
    check("R5 busy on exit", int'(busy), 1);
    check("R6 irq not early", int'(wake_irq), 0);
    wait_settle("R1 exit");
    check_period("R1 pll drive", 2.0 * PLL_HALF);
    check("R6 irq after exit", int'(wake_irq), 1);
    check("R4 released", int'(pll_rst_n), 1);
  endtask

  task automatic t_sticky_clear();
    repeat (20) @(negedge osc_clk);
    check("R6 sticky", int'(wake_irq), 1);
    irq_clr = 1'b1;
    @(negedge osc_clk);
    irq_clr = 1'b0;
    check("R7 cleared", int'(wake_irq), 0);
    repeat (5) @(negedge osc_clk);
    check("R7 stays clear", int'(wake_irq), 0);
  endtask

  task automatic t_safe();
    safe_force = 1'b1;
    @(negedge osc_clk);
    check("R9 busy on force", int'(busy), 1);
    check("R4 asserted", int'(pll_rst_n), 0);
    wait_settle("R9 force");
    check_period("R9 forced bypass", 2.0 * REF_HALF);
    check("R9 irq on force", int'(wake_irq), 1);
    irq_clr = 1'b1;
    @(negedge osc_clk);
    irq_clr = 1'b0;
    src_sel = 1'b0;
    @(negedge osc_clk);
    wait_settle("R2 osc again");
    check_period("R2 osc again", 2.0 * OSC_HALF);
    safe_force = 1'b0;
    @(negedge osc_clk);
    wait_settle("R9 release");
    check_period("R9 back to pll", 2.0 * PLL_HALF);
    check("R4 released again", int'(pll_rst_n), 1);
  endtask

  initial begin
    #(200000.0 * 2.0 * OSC_HALF);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge osc_clk);
    t_reset();
    t_bypass_osc();
    t_src_ref();
    t_exit();
    t_sticky_clear();
    t_safe();
    check("R3 short phases", glitches, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule